// File: doc/BRIEF.md
# Flash Page Programming Engine with Read-Back Retry

This block writes one page of a byte-wide parallel flash from a local source buffer and confirms the result. A single start pulse latches the page base address and the page size (as a power-of-two exponent). Each attempt sends the three-write program unlock prefix and then walks the page offsets in ascending order. It writes each source byte to the matching flash address, except that an erased-value byte (0xFF) is skipped.

After the data phase the engine polls the last address of the page. It watches bit 6 of the returned data until two reads in a row agree, or until a bounded number of comparisons has been spent. It then reads the whole page back and compares every byte with the source buffer. A mismatch sends the engine back to a fresh attempt while retries remain. When the page verifies, or when the retries are used up, the engine pulses `done`. It also drives `fail` and the index of the page that failed.

The source buffer and the flash read path are both treated as combinational reads: data for the address driven in a cycle is sampled at the end of that same cycle.

Top module: `pgprog_engine`

## Requirements
- R1: Every attempt opens with exactly three write cycles, in this order: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Data writes follow, and no other write comes between the prefix and the data.
- R2: Source byte i goes to address base+i for i from 0 to size-1 in ascending order. A source byte equal to 0xFF produces no write cycle, yet the next byte still lands at its own address.
- R3: The first read after the data writes targets address base+size-1. The device counts as ready as soon as bit 6 of a read equals bit 6 of the read just before it.
- R4: If bit 6 keeps changing, polling stops after POLL_LIMIT comparison reads, so one poll uses at most 1+POLL_LIMIT reads. The engine then proceeds to read-back as if the device were ready.
- R5: After polling, every byte from base to base+size-1 is read once and compared with the source byte at the same offset.
- R6: A read-back mismatch starts a complete new attempt while fewer than RETRY_LIMIT retries have been taken. At most RETRY_LIMIT+1 attempts are made.
- R7: When the last permitted attempt still mismatches, `fail` is 1 and `fail_page` equals base >> size exponent. `fail` rises in the same cycle as `done`.
- R8: `done` is high for exactly one cycle per accepted start. `fail` keeps its value while idle and is cleared in the cycle after the next accepted start.
- R9: A start pulse arriving while an operation is in progress is ignored: no second `done` appears and the latched page does not change.
- R10: During and after reset, and whenever the engine is idle, no flash read or write cycle is driven, and `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin programming one page (accepted only when idle) |
| page_base | input | AW | Flash address of the first page byte |
| pg_shift | input | SW | Page size exponent; page holds 2**pg_shift bytes, at most 2**MAX_PG_SHIFT |
| src_addr | output | MAX_PG_SHIFT | Offset into the source buffer |
| src_data | input | 8 | Source byte at `src_addr`, same-cycle |
| fl_addr | output | AW | Flash address of the current bus cycle |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | One flash write cycle |
| fl_re | output | 1 | One flash read cycle |
| fl_rdata | input | 8 | Flash read data for `fl_addr`, same-cycle |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Page did not verify after all attempts |
| fail_page | output | AW | Index of the failed page (base >> pg_shift) |

## Verification
The bench builds the engine with a 16-bit address, pages up to 16 bytes, a poll limit of 8 comparisons and a retry limit of 3. With these values a permanently toggling device exhausts polling on every attempt in a short run. A cell that refuses its first few writes also reaches the retry boundary from both sides: it passes on the fourth attempt and fails when it needs a fifth. The behavioural flash model checks the unlock order, refuses out-of-window and 0xFF writes, and counts reads. This lets single-byte, full-size and all-erased pages be judged by their bus traffic as well as by the final memory contents.

// File: rtl/pgprog_pkg.sv
// Package: shared state encoding and the fixed unlock prefix for the
// page programming engine. Assumes a byte-wide flash whose command
// addresses fit in 16 bits.
package pgprog_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLK,
        S_DATA,
        S_PREF,
        S_POLL,
        S_CHECK,
        S_DECIDE,
        S_FINISH
    } pp_state_e;

    localparam logic [15:0] CMD_ADDR_A = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;

    // Address of unlock step 0..2
    function automatic logic [15:0] unlk_addr(input logic [1:0] step);
        return (step == 2'd1) ? CMD_ADDR_B : CMD_ADDR_A;
    endfunction

    // Data of unlock step 0..2
    function automatic logic [7:0] unlk_data(input logic [1:0] step);
        case (step)
            2'd0:    return 8'hAA;
            2'd1:    return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/pp_toggle_poll.sv
// Toggle-bit readiness detector. On load it stores the sampled bit as
// the reference; on each step it replaces the reference and counts one
// comparison. agree/expire are combinational views of the current read.
// Assumes LIMIT >= 1.
module pp_toggle_poll #(
    parameter int LIMIT = 268435455,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          sample,
    output logic          agree,
    output logic          expire,
    output logic [CW-1:0] cnt
);

    logic prev_q;

    // Track the previous bit and the number of comparisons spent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            prev_q <= sample;
            cnt    <= '0;
        end else if (step) begin
            prev_q <= sample;
            cnt    <= cnt + 1'b1;
        end
    end

    assign agree  = (sample == prev_q);
    assign expire = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/pp_retry_ctr.sv
// Retry counter: cleared at an accepted start, incremented for each
// repeated attempt. can_retry is high while fewer than LIMIT retries
// have been taken.
module pp_retry_ctr #(
    parameter int LIMIT = 16,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          can_retry,
    output logic [CW-1:0] cnt
);

    // Count retries taken for the current page
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign can_retry = (cnt < CW'(LIMIT));

endmodule

// File: rtl/pp_cmp_acc.sv
// Read-back comparator: accumulates a sticky mismatch flag over one
// verify pass. clr wins over en.
module pp_cmp_acc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] got,
    input  logic [DW-1:0] want,
    output logic          mism
);

    // Sticky mismatch across the bytes of one pass
    always_ff @(posedge clk) begin
        if (!rst_n)   mism <= 1'b0;
        else if (clr) mism <= 1'b0;
        else if (en && (got != want)) mism <= 1'b1;
    end

endmodule

// File: rtl/pgprog_engine.sv
// Page programming engine. Per attempt: unlock prefix, data writes
// (0xFF skipped), toggle-bit poll on the last page byte, full read-back.
// Mismatch repeats the attempt up to RETRY_LIMIT times.
// Assumes: AW >= 16, page_base aligned to the page size, pg_shift no
// larger than MAX_PG_SHIFT, and same-cycle source and flash reads.
module pgprog_engine
    import pgprog_pkg::*;
#(
    parameter int AW           = 20,
    parameter int MAX_PG_SHIFT = 8,
    parameter int POLL_LIMIT   = 268435455,
    parameter int RETRY_LIMIT  = 16,
    localparam int OW  = MAX_PG_SHIFT,
    localparam int SW  = $clog2(MAX_PG_SHIFT + 1),
    localparam int PCW = $clog2(POLL_LIMIT + 1),
    localparam int RCW = $clog2(RETRY_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] page_base,
    input  logic [SW-1:0] pg_shift,
    output logic [OW-1:0] src_addr,
    input  logic [7:0]    src_data,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [7:0]    fl_rdata,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_page
);

    pp_state_e     state;
    logic [AW-1:0] base_q;
    logic [SW-1:0] shift_q;
    logic [OW-1:0] off_q;
    logic [1:0]    uidx;
    logic          fail_q;

    logic [OW:0]   span;
    logic [OW:0]   span_m1;
    logic [OW-1:0] last_off;
    logic          at_last;
    logic          busy;

    logic            poll_agree;
    logic            poll_expire;
    logic [PCW-1:0]  poll_cnt;
    logic            can_retry;
    logic [RCW-1:0]  retry_cnt;
    logic            mism;
    logic            retry_now;

    // Last offset of the latched page
    assign span     = (OW+1)'(1) << shift_q;
    assign span_m1  = span - (OW+1)'(1);
    assign last_off = span_m1[OW-1:0];
    assign at_last  = (off_q == last_off);
    assign busy     = (state != S_IDLE);
    assign retry_now = (state == S_DECIDE) && mism && can_retry;

    pp_toggle_poll #(
        .LIMIT (POLL_LIMIT),
        .CW    (PCW)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == S_PREF),
        .step   ((state == S_POLL) && !poll_agree && !poll_expire),
        .sample (fl_rdata[6]),
        .agree  (poll_agree),
        .expire (poll_expire),
        .cnt    (poll_cnt)
    );

    pp_retry_ctr #(
        .LIMIT (RETRY_LIMIT),
        .CW    (RCW)
    ) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       ((state == S_IDLE) && start),
        .inc       (retry_now),
        .can_retry (can_retry),
        .cnt       (retry_cnt)
    );

    pp_cmp_acc #(
        .DW (8)
    ) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_UNLK),
        .en    (state == S_CHECK),
        .got   (fl_rdata),
        .want  (src_data),
        .mism  (mism)
    );

    // Sequencer: attempt phases, page offset walk and final verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            base_q  <= '0;
            shift_q <= '0;
            off_q   <= '0;
            uidx    <= '0;
            fail_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        base_q  <= page_base;
                        shift_q <= pg_shift;
                        fail_q  <= 1'b0;
                        uidx    <= '0;
                        state   <= S_UNLK;
                    end
                end
                S_UNLK: begin
                    uidx <= uidx + 2'd1;
                    if (uidx == 2'd2) begin
                        off_q <= '0;
                        state <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (at_last) state <= S_PREF;
                    else         off_q <= off_q + 1'b1;
                end
                S_PREF: begin
                    state <= S_POLL;
                end
                S_POLL: begin
                    if (poll_agree || poll_expire) begin
                        off_q <= '0;
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (at_last) state <= S_DECIDE;
                    else         off_q <= off_q + 1'b1;
                end
                S_DECIDE: begin
                    if (retry_now) begin
                        uidx  <= '0;
                        state <= S_UNLK;
                    end else begin
                        fail_q <= mism;
                        state  <= S_FINISH;
                    end
                end
                S_FINISH: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Flash bus drive for the current phase
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = src_data;
        fl_addr  = base_q + AW'(off_q);
        case (state)
            S_UNLK: begin
                fl_we    = 1'b1;
                fl_wdata = unlk_data(uidx);
                fl_addr  = AW'(unlk_addr(uidx));
            end
            S_DATA:  fl_we = (src_data != 8'hFF);
            S_PREF,
            S_POLL: begin
                fl_re   = 1'b1;
                fl_addr = base_q + AW'(last_off);
            end
            S_CHECK: fl_re = 1'b1;
            default: ;
        endcase
    end

    assign src_addr  = off_q;
    assign done      = (state == S_FINISH);
    assign fail      = fail_q;
    assign fail_page = base_q >> shift_q;

endmodule

// File: rtl/pgprog_engine_chk.sv
// Checker for the page programming engine, bound to every instance.
// Observes ports plus the retry and poll counters.
module pgprog_engine_chk #(
    parameter int POLL_LIMIT  = 8,
    parameter int RETRY_LIMIT = 3,
    parameter int PCW         = 4,
    parameter int RCW         = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           fl_we,
    input logic           fl_re,
    input logic [7:0]     fl_wdata,
    input logic           done,
    input logic           fail,
    input logic [PCW-1:0] poll_cnt,
    input logic [RCW-1:0] retry_cnt
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(fail)); // R8

    AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done); // R7

    AST_NO_ERASED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (fl_wdata != 8'hFF)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(fl_we || fl_re)); // R10

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= RCW'(RETRY_LIMIT)); // R6

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < PCW'(POLL_LIMIT)); // R4

endmodule

bind pgprog_engine pgprog_engine_chk #(
    .POLL_LIMIT  (POLL_LIMIT),
    .RETRY_LIMIT (RETRY_LIMIT),
    .PCW         (PCW),
    .RCW         (RCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .fl_we     (fl_we),
    .fl_re     (fl_re),
    .fl_wdata  (fl_wdata),
    .done      (done),
    .fail      (fail),
    .poll_cnt  (poll_cnt),
    .retry_cnt (retry_cnt)
);

// File: tb/pgprog_engine_tb.sv
module pgprog_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int MPS = 4;
    localparam int PL  = 8;
    localparam int RL  = 3;
    localparam int SW  = $clog2(MPS + 1);

    typedef struct packed {
        logic [15:0] base;
        logic [2:0]  shift;
        logic [7:0]  seed;
        logic        allff;
        logic [3:0]  weak_off;
        logic [3:0]  weak_n;
        logic [3:0]  busy_k;
        logic        stuck;
        logic        exp_fail;
        logic [3:0]  exp_att;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 3'd2, 8'h12, 1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 1'b0, 4'd1},
        '{16'h0040, 3'd4, 8'h5A, 1'b0, 4'd1, 4'd2, 4'd5, 1'b0, 1'b0, 4'd3},
        '{16'h0100, 3'd3, 8'h33, 1'b0, 4'd2, 4'd3, 4'd2, 1'b0, 1'b0, 4'd4},
        '{16'h0180, 3'd3, 8'h44, 1'b0, 4'd0, 4'd4, 4'd1, 1'b0, 1'b1, 4'd4},
        '{16'h0200, 3'd0, 8'hC3, 1'b0, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0, 4'd1},
        '{16'h0300, 3'd4, 8'h77, 1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1, 4'd4},
        '{16'h0400, 3'd3, 8'hFF, 1'b1, 4'd0, 4'd0, 4'd4, 1'b0, 1'b0, 4'd1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  page_base = '0;
    logic [SW-1:0]  pg_shift = '0;
    logic [MPS-1:0] src_addr;
    logic [7:0]     src_data;
    logic [AW-1:0]  fl_addr;
    logic [7:0]     fl_wdata;
    logic           fl_we;
    logic           fl_re;
    logic [7:0]     fl_rdata;
    logic           done;
    logic           fail;
    logic [AW-1:0]  fail_page;

    // Bench-side configuration of the flash model
    logic [7:0]  src_buf [16];
    logic        erase_req = 1'b0;
    logic [15:0] cfg_base = '0;
    int          cfg_len = 0;
    logic [15:0] cfg_weak = '0;
    int          cfg_weak_n = 0;
    int          cfg_busy = 0;
    logic        cfg_stuck = 1'b0;

    // Flash model state
    logic [7:0]  mem [4096];
    int          seq, proto_err, ff_wr, attempts, busy_left, weak_left, reads, done_cnt;
    logic        tog;
    logic [15:0] first_rd;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_data = src_buf[src_addr];

    pgprog_engine #(
        .AW           (AW),
        .MAX_PG_SHIFT (MPS),
        .POLL_LIMIT   (PL),
        .RETRY_LIMIT  (RL)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .page_base (page_base),
        .pg_shift  (pg_shift),
        .src_addr  (src_addr),
        .src_data  (src_data),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_we     (fl_we),
        .fl_re     (fl_re),
        .fl_rdata  (fl_rdata),
        .done      (done),
        .fail      (fail),
        .fail_page (fail_page)
    );

    // Flash read data: toggling status while busy, array contents otherwise
    always_comb begin
        if (busy_left > 0 || cfg_stuck) fl_rdata = {1'b0, tog, 6'b0};
        else                            fl_rdata = mem[fl_addr[11:0]];
    end

    // Flash behaviour: unlock tracking, programming, busy toggling, counters
    always_ff @(posedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
            seq <= 0; proto_err <= 0; ff_wr <= 0; attempts <= 0;
            busy_left <= 0; weak_left <= cfg_weak_n; reads <= 0;
            done_cnt <= 0; tog <= 1'b0; first_rd <= 16'hFFFF;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (fl_we) begin
                if (fl_wdata == 8'hFF) ff_wr <= ff_wr + 1;
                case (seq)
                    0: if (fl_addr == 16'h5555 && fl_wdata == 8'hAA) seq <= 1;
                       else proto_err <= proto_err + 1;
                    1: if (fl_addr == 16'h2AAA && fl_wdata == 8'h55) seq <= 2;
                       else begin proto_err <= proto_err + 1; seq <= 0; end
                    2: if (fl_addr == 16'h5555 && fl_wdata == 8'hA0) begin
                           seq <= 3; attempts <= attempts + 1;
                       end else begin proto_err <= proto_err + 1; seq <= 0; end
                    default: begin
                        if (fl_addr >= cfg_base && int'(fl_addr - cfg_base) < cfg_len) begin
                            busy_left <= cfg_busy;
                            if (fl_addr == cfg_weak && weak_left > 0)
                                weak_left <= weak_left - 1;
                            else
                                mem[fl_addr[11:0]] <= mem[fl_addr[11:0]] & fl_wdata;
                        end else proto_err <= proto_err + 1;
                    end
                endcase
            end
            if (fl_re) begin
                if (seq == 3 && first_rd == 16'hFFFF) first_rd <= fl_addr;
                seq <= 0;
                reads <= reads + 1;
                if (busy_left > 0 || cfg_stuck) begin
                    tog <= ~tog;
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic erase_model();
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R8 done reached", int'(done), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int len = 1 << v.shift;
        int bad = 0;
        int exp_page = int'(v.base) >> v.shift;
        for (int i = 0; i < 16; i++)
            src_buf[i] = (v.allff || (i % 4) == 3) ? 8'hFF : (v.seed ^ 8'(i * 7));
        cfg_base = v.base; cfg_len = len; cfg_weak = v.base + 16'(v.weak_off);
        cfg_weak_n = int'(v.weak_n); cfg_busy = int'(v.busy_k); cfg_stuck = v.stuck;
        erase_model();
        page_base = v.base; pg_shift = v.shift; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(fail == 1'b0, "R8 fail cleared after start", int'(fail), 0);
        wait_done();
        check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        check(proto_err == 0, "R1 unlock order and write window", proto_err, 0);
        check(attempts == int'(v.exp_att), "R6 attempt count", attempts, int'(v.exp_att));
        check(ff_wr == 0, "R2 no 0xFF written", ff_wr, 0);
        check(fail == v.exp_fail, "R7 fail verdict", int'(fail), int'(v.exp_fail));
        check(int'(first_rd) == int'(v.base) + len - 1, "R3 poll at last byte",
              int'(first_rd), int'(v.base) + len - 1);
        if (v.exp_fail) begin
            repeat (4) @(negedge clk);
            check(fail == 1'b1, "R8 fail held while idle", int'(fail), 1);
            check(int'(fail_page) == exp_page, "R7 failing page index", int'(fail_page), exp_page);
        end else begin
            for (int i = 0; i < len; i++)
                if (mem[12'(int'(v.base) + i)] != src_buf[i]) bad++;
            check(bad == 0, "R2 R5 page contents", bad, 0);
        end
        if (v.stuck)
            check(reads == 4 * (1 + PL + len), "R4 poll gives up", reads, 4 * (1 + PL + len));
        if (idx == 0)
            check(reads == 9, "R3 ready on two agreeing reads", reads, 9);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) src_buf[i] = 8'h00;
        erase_req = 1'b1;
        repeat (4) @(negedge clk);
        erase_req = 1'b0;
        // R10 reset state
        check(!done && !fail && !fl_we && !fl_re, "R10 quiet in reset",
              int'({done, fail, fl_we, fl_re}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !fail && !fl_we && !fl_re, "R10 quiet after reset",
              int'({done, fail, fl_we, fl_re}), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R9: second start during a run is ignored
        for (int i = 0; i < 16; i++) src_buf[i] = 8'h30 + 8'(i);
        cfg_base = 16'h0500; cfg_len = 8; cfg_weak = 16'hFFFF; cfg_weak_n = 0;
        cfg_busy = 2; cfg_stuck = 1'b0;
        erase_model();
        page_base = 16'h0500; pg_shift = 3'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        page_base = 16'h0600; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        check(done_cnt == 1, "R9 no extra done", done_cnt, 1);
        check(attempts == 1 && proto_err == 0, "R9 latched page kept", proto_err, 0);
        check(mem[12'h500] == 8'h30 && mem[12'h600] == 8'hFF, "R9 data at first page",
              int'(mem[12'h600]), 8'hFF);
        check(!fl_we && !fl_re, "R10 idle bus quiet", int'({fl_we, fl_re}), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule